// File: doc/BRIEF.md
# Random Frame-Gating Anti-Collision Scheduler

This block decides, one frame at a time, whether a contactless tag transmits its identifier and listens for reader commands. When several tags share the field, each one sits out a random number of frames between transmissions. Two tags that collide in one frame are then unlikely to collide again in the next. The mean spacing between active frames is chosen by a 2-bit option. One option value turns the randomisation off, so that the tag answers in every frame.

A frame-start strobe marks each frame. On that strobe the scheduler either raises `tx_en` for the whole frame or holds it low and counts down the remaining skipped frames. After every active frame it draws a new gap from a 16-bit maximal-length LFSR. The gap is uniform over 0 to 2N−1 skipped frames, where N is the selected average. Command acceptance (`cmd_en`) is open only during the first listening window of a frame in which the tag transmitted. A silence command accepted there sets a flag. Only power-on reset clears that flag, and while it is set the tag never transmits again.

Top module: `frame_gate_sched`

## Requirements
- R1: While `rst_n` is low, `tx_en` and `cmd_en` are 0. The first frame after reset is always active (the gap counter resets to 0).
- R2: With `rand_mode` 2'b01, 2'b10 or 2'b11 the average N is 8, 32 or 128 frames. After each active frame the number of skipped frames lies in 0 to 2N−1, so the mean spacing between active frames is about N.
- R3: With `rand_mode` 2'b00 every frame is active.
- R4: In a skipped frame `tx_en` is 0 for the whole frame and `cmd_en` stays 0 even while `listen_win` is high.
- R5: `cmd_en` is 1 only while `listen_win` is high during the first listening window of an active frame. A second window in the same frame gives `cmd_en` = 0.
- R6: `disable_cmd` seen while `cmd_en` is 1 clears `tx_en` on the next clock and keeps it 0 in every later frame until `rst_n` goes low. `disable_cmd` seen while `cmd_en` is 0 has no effect.
- R7: The LFSR state is never zero. A gap of zero skipped frames can occur, so two active frames can follow back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| frame_start | input | 1 | One-cycle strobe at the start of each frame |
| rand_mode | input | 2 | 00 always active, 01 mean 8, 10 mean 32, 11 mean 128 |
| listen_win | input | 1 | High during a listening window |
| disable_cmd | input | 1 | Decoded silence-command strobe |
| tx_en | output | 1 | Tag transmits its ID in the current frame |
| cmd_en | output | 1 | Commands may be accepted now |

## Verification
The bench builds the block with its default parameters: a 16-bit LFSR, mean-8 base and a 4x step per mode. These give an 8-bit gap counter, so all three averages fit in a few thousand frames. Three thousand frames per random mode give enough active frames to check the upper gap bound. The same runs show back-to-back activity in the mean-8 mode and bring the measured spacing inside a factor of two of N. With randomisation off, silencing can be placed in a known frame. The skipped frames of the mean-8 mode expose attempts to silence the tag in frames where it is inactive.

// File: rtl/fgs_pkg.sv
package fgs_pkg;

  typedef enum logic [1:0] {
    MODE_ALWAYS = 2'b00,
    MODE_AVG_A  = 2'b01,
    MODE_AVG_B  = 2'b10,
    MODE_AVG_C  = 2'b11
  } fgs_mode_e;

  // Mask of 2N-1 for the chosen mode; N = 2**(base_log2 + step_log2*(mode-1)).
  function automatic logic [15:0] gap_mask(input logic [1:0] mode,
                                            input int base_log2,
                                            input int step_log2);
    int sh;
    if (mode == MODE_ALWAYS) return 16'd0;
    sh = base_log2 + 1 + step_log2 * (int'(mode) - 1);
    return 16'((32'd1 << sh) - 32'd1);
  endfunction

  // Fibonacci shift-left step with an XOR tap mask.
  function automatic logic [15:0] lfsr_step(input logic [15:0] s,
                                             input logic [15:0] taps);
    return {s[14:0], ^(s & taps)};
  endfunction

endpackage

// File: rtl/fgs_lfsr.sv
module fgs_lfsr #(
  parameter int          W    = 16,
  parameter logic [15:0] TAPS = 16'hB400,
  parameter logic [15:0] SEED = 16'hACE1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  output logic [W-1:0] state
);
  import fgs_pkg::*;

  logic [15:0] nxt;
  assign nxt = lfsr_step(16'(state), TAPS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    state <= W'(SEED);
    else if (step) state <= W'(nxt);
  end

  AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    state != '0); // R7

endmodule

// File: rtl/fgs_gap_counter.sv
module fgs_gap_counter #(
  parameter int GAP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_start,
  input  logic             disabled,
  input  logic             disable_hit,
  input  logic [GAP_W-1:0] draw,
  output logic             frame_fire,
  output logic             frame_skip,
  output logic             tx_en_q,
  output logic [GAP_W-1:0] gap_q
);
  assign frame_fire = frame_start && !disabled && (gap_q == '0);
  assign frame_skip = frame_start && !disabled && (gap_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_en_q <= 1'b0;
      gap_q   <= '0;
    end else begin
      if (disable_hit || disabled) tx_en_q <= 1'b0;
      else if (frame_start)        tx_en_q <= frame_fire;
      if (frame_fire)      gap_q <= draw;
      else if (frame_skip) gap_q <= gap_q - 1'b1;
    end
  end

  AST_GAP_WITHIN_DRAW: assert property (@(posedge clk) disable iff (!rst_n)
    frame_fire |=> gap_q == $past(draw)); // R2
  AST_SKIP_COUNTS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    frame_skip |=> (gap_q == $past(gap_q) - 1'b1) && !tx_en_q); // R4
  AST_SILENT_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    disabled |=> !tx_en_q); // R6

endmodule

// File: rtl/fgs_window_gate.sv
module fgs_window_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_start,
  input  logic tx_en,
  input  logic listen_win,
  input  logic disable_cmd,
  output logic cmd_en,
  output logic disable_hit,
  output logic disabled_q
);
  logic listen_q;
  logic win_done_q;
  logic win_closed;

  assign win_closed  = listen_q && !listen_win;
  assign cmd_en      = tx_en && listen_win && !win_done_q && !disabled_q;
  assign disable_hit = cmd_en && disable_cmd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      listen_q   <= 1'b0;
      win_done_q <= 1'b0;
      disabled_q <= 1'b0;
    end else begin
      listen_q <= listen_win;
      if (frame_start)     win_done_q <= 1'b0;
      else if (win_closed) win_done_q <= 1'b1;
      if (disable_hit) disabled_q <= 1'b1;
    end
  end

  AST_DISABLE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    disabled_q |=> disabled_q); // R6
  AST_ONE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (win_closed && !frame_start) |=> !cmd_en); // R5
  AST_HIT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    disable_hit |=> disabled_q && !cmd_en); // R6

endmodule

// File: rtl/frame_gate_sched.sv
module frame_gate_sched #(
  parameter int          LFSR_W    = 16,
  parameter logic [15:0] LFSR_TAPS = 16'hB400,
  parameter logic [15:0] LFSR_SEED = 16'hACE1,
  parameter int          BASE_LOG2 = 3,
  parameter int          STEP_LOG2 = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_start,
  input  logic [1:0] rand_mode,
  input  logic       listen_win,
  input  logic       disable_cmd,
  output logic       tx_en,
  output logic       cmd_en
);
  import fgs_pkg::*;

  localparam int GAP_W = BASE_LOG2 + 1 + 2 * STEP_LOG2;

  logic [LFSR_W-1:0] lfsr_q;
  logic [15:0]       mask;
  logic [GAP_W-1:0]  draw;
  logic [GAP_W-1:0]  gap_q;
  logic              frame_fire, frame_skip;
  logic              disable_hit, disabled_q;

  assign mask = gap_mask(rand_mode, BASE_LOG2, STEP_LOG2);
  assign draw = GAP_W'(16'(lfsr_q) & mask);

  fgs_lfsr #(.W(LFSR_W), .TAPS(LFSR_TAPS), .SEED(LFSR_SEED)) u_lfsr (
    .clk(clk), .rst_n(rst_n), .step(frame_start), .state(lfsr_q));

  fgs_gap_counter #(.GAP_W(GAP_W)) u_gap (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .disabled(disabled_q), .disable_hit(disable_hit), .draw(draw),
    .frame_fire(frame_fire), .frame_skip(frame_skip),
    .tx_en_q(tx_en), .gap_q(gap_q));

  fgs_window_gate u_win (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .tx_en(tx_en),
    .listen_win(listen_win), .disable_cmd(disable_cmd), .cmd_en(cmd_en),
    .disable_hit(disable_hit), .disabled_q(disabled_q));

  AST_ALWAYS_MODE_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && !disabled_q && rand_mode == MODE_ALWAYS) |=> tx_en); // R3
  AST_GAP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    frame_fire |=> 16'(gap_q) <= $past(mask)); // R2

endmodule

// File: tb/frame_gate_sched_test.sv
module frame_gate_sched_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_start = 1'b0;
  logic [1:0] rand_mode = 2'b00;
  logic listen_win = 1'b0;
  logic disable_cmd = 1'b0;
  logic tx_en, cmd_en;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  frame_gate_sched uut (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .rand_mode(rand_mode),
    .listen_win(listen_win), .disable_cmd(disable_cmd),
    .tx_en(tx_en), .cmd_en(cmd_en));

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset(input logic [1:0] mode);
    rand_mode = mode;
    @(negedge clk); rst_n = 1'b0; listen_win = 1'b1;
    repeat (2) @(negedge clk);
    check(tx_en == 1'b0, "R1", "tx_en in reset", int'(tx_en), 0);
    check(cmd_en == 1'b0, "R1", "cmd_en in reset", int'(cmd_en), 0);
    listen_win = 1'b0; rst_n = 1'b1;
    @(negedge clk);
  endtask

  // One frame: strobe, window (optionally with silence), gap, optional second window.
  task automatic run_frame(input bit dis, input bit second_win,
                           output bit tx, output bit cmd, output bit cmd2);
    @(negedge clk); frame_start = 1'b1;
    @(negedge clk); frame_start = 1'b0; listen_win = 1'b1; disable_cmd = dis;
    #1; tx = tx_en; cmd = cmd_en;
    @(negedge clk); listen_win = 1'b0; disable_cmd = 1'b0;
    @(negedge clk);
    cmd2 = 1'b0;
    if (second_win) begin
      listen_win = 1'b1; #1; cmd2 = cmd_en;
      @(negedge clk); listen_win = 1'b0;
    end
  endtask

  task automatic t_reset_and_always;
    bit tx, cmd, c2;
    int act = 0;
    do_reset(2'b00);
    for (int i = 0; i < 40; i++) begin
      run_frame(1'b0, 1'b0, tx, cmd, c2);
      if (tx && cmd) act++;
    end
    check(act == 40, "R3", "active frames with randomisation off", act, 40);
    run_frame(1'b0, 1'b1, tx, cmd, c2);
    check(cmd == 1'b1, "R5", "cmd_en in first window", int'(cmd), 1);
    check(c2 == 1'b0, "R5", "cmd_en in second window", int'(c2), 0);
  endtask

  task automatic t_random(input logic [1:0] mode, input int n, input int frames);
    bit tx, cmd, c2, prev_tx;
    int act = 0, skip = 0, max_skip = 0, b2b = 0, mism = 0;
    do_reset(mode);
    run_frame(1'b0, 1'b0, tx, cmd, c2);
    check(tx == 1'b1, "R1", "first frame after reset active", int'(tx), 1);
    prev_tx = tx; act = 1;
    for (int i = 1; i < frames; i++) begin
      run_frame(1'b0, 1'b0, tx, cmd, c2);
      if (cmd != tx) mism++;
      if (tx) begin
        act++;
        if (skip > max_skip) max_skip = skip;
        if (prev_tx) b2b++;
        skip = 0;
      end else skip++;
      prev_tx = tx;
    end
    check(max_skip <= 2*n - 1, "R2", $sformatf("max skipped frames mode %0d", mode),
          max_skip, 2*n - 1);
    check(max_skip > 0, "R2", "some frames skipped", max_skip, 1);
    check(frames / act >= n / 2 && frames / act <= 2 * n, "R2",
          $sformatf("mean spacing mode %0d", mode), frames / act, n);
    check(mism == 0, "R4", "cmd_en differs from tx_en in window", mism, 0);
    if (mode == 2'b01)
      check(b2b > 0, "R7", "back-to-back active frames", b2b, 1);
  endtask

  task automatic t_disable_active;
    bit tx, cmd, c2;
    int later = 0;
    do_reset(2'b00);
    run_frame(1'b1, 1'b0, tx, cmd, c2);
    check(tx && cmd, "R6", "silence accepted in active window", int'(cmd), 1);
    for (int i = 0; i < 30; i++) begin
      run_frame(1'b0, 1'b0, tx, cmd, c2);
      if (tx || cmd) later++;
    end
    check(later == 0, "R6", "frames active after silence", later, 0);
    do_reset(2'b00);
    run_frame(1'b0, 1'b0, tx, cmd, c2);
    check(tx == 1'b1, "R6", "reset clears silence", int'(tx), 1);
  endtask

  task automatic t_disable_ignored;
    bit tx, cmd, c2;
    int act = 0, lcmd = 0, tries = 0;
    // Silence outside listening window in an active frame
    do_reset(2'b00);
    @(negedge clk); frame_start = 1'b1;
    @(negedge clk); frame_start = 1'b0; disable_cmd = 1'b1;
    @(negedge clk); disable_cmd = 1'b0;
    @(negedge clk);
    run_frame(1'b0, 1'b0, tx, cmd, c2);
    check(tx == 1'b1, "R6", "silence outside window ignored", int'(tx), 1);
    // Silence during skipped frames (mean 8)
    do_reset(2'b01);
    for (int i = 0; i < 400; i++) begin
      run_frame(1'b0, 1'b0, tx, cmd, c2);
      if (!tx) break;
    end
    for (int i = 0; i < 400; i++) begin
      run_frame(!tx && tries < 3, 1'b0, tx, cmd, c2);
      if (!tx) begin
        tries++;
        if (cmd) lcmd++;
      end
      if (tx) act++;
      if (tries >= 3 && act > 0) break;
    end
    check(lcmd == 0, "R4", "cmd_en in skipped frame", lcmd, 0);
    check(act > 0, "R6", "active after silence in skipped frames", act, 1);
  endtask

  initial begin
    #1500000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset_and_always();
    t_random(2'b01, 8, 3000);
    t_random(2'b10, 32, 3000);
    t_random(2'b11, 128, 3000);
    t_disable_active();
    t_disable_ignored();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule